// File: doc/BRIEF.md
# Black-Level Clamp Servo

This block holds the black level of an image sensor signal chain at a chosen code. While a clamp-window strobe marks the shielded pixels of a line, it adds up how far each converter sample lies from a programmable 8-bit target. When the next line starts, it turns that sum into a window average. A gain shift filters the average, and the result is added to a signed correction word that drives an offset DAC upstream of the converter. The update can run on every line or only on every (N+1)-th line.

When the loop is switched off, the correction word stops tracking. It then carries the target value itself, so the same setting serves as a fixed, programmable offset. When the loop is switched back on, the servo starts from that offset. A window should cover at least 20 pixels. Shorter windows still work but give a noisier estimate.

Top module: `clamp_servo`

## Requirements
- R1: After reset `corr_out` is 0, the line-rate counter is 0 and the window holds no samples.
- R2: Only samples taken in cycles with `win_en` high count toward the window. Codes outside the window have no effect. A sample taken in a cycle where `line_start` is high opens the new line's window and does not count toward the line that just ended.
- R3: The window average is the sum of (`adc_code` − `black_tgt`) over the counted samples. This sum is arithmetic-shifted right by floor(log2(sample count)), which is the count rounded down to a power of two.
- R4: An update adds (average >>> `gain_sh`) to `corr_out`, using an arithmetic shift. The update happens on the clock edge that samples `line_start` high, so the new value shows one cycle after the `line_start` cycle.
- R5: `corr_out` saturates to the signed 10-bit range −512..511. It never wraps.
- R6: A line whose window held zero samples leaves `corr_out` unchanged.
- R7: Each `line_start` either fires the line-rate counter or increments it. The counter fires when its value is at least `line_div`, and then it returns to 0. With `line_div` = N, an update therefore comes on every (N+1)-th line after reset. A line that does not fire leaves `corr_out` unchanged. A firing line with an empty window uses up its slot.
- R8: While `loop_on` is low, `corr_out` equals `black_tgt` zero-extended, from the cycle after each edge. After `loop_on` returns high, updates start from that value.
- R9: With `loop_on` high, `corr_out` changes only on an edge that samples `line_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| win_en | input | 1 | Clamp-window strobe over the shielded pixels |
| adc_code | input | 12 | Converter sample, straight binary |
| black_tgt | input | 8 | Target black level, 0..255 |
| loop_on | input | 1 | 1 = servo runs, 0 = fixed offset from `black_tgt` |
| line_div | input | 4 | Update on every (line_div+1)-th line |
| gain_sh | input | 3 | Filter shift k in corr += err >>> k |
| corr_out | output | 10 | Signed correction word for the offset DAC |

## Verification
The only result the block produces is `corr_out`. It can move on exactly one edge per line: the edge that samples `line_start` high. The new word is valid in the cycle after the `line_start` cycle. The stimulus task drives `line_start` on a falling edge and, at the same moment, enqueues the value the requirements predict. The monitor notes at the following rising edge that a line ended, then pops the queue and compares at the falling edge after that, so every check lands in the second half of the cycle where the new value is due. Disabled-loop lines follow the same one-cycle timing, because the offset is also registered.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   localparam int DEF_CODE_W = 12;
   localparam int DEF_TGT_W  = 8;
   localparam int DEF_CORR_W = 10;
   localparam int DEF_CNT_W  = 11;
   localparam int DEF_DIV_W  = 4;
   localparam int DEF_GAIN_W = 3;

   // width of a shift amount able to address 0..w
   function automatic int shift_width(input int w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/clamp_win_acc.sv
module clamp_win_acc #(
   parameter int CODE_W = 12,
   parameter int TGT_W  = 8,
   parameter int CNT_W  = 11,
   parameter int ACC_W  = CODE_W + 1 + CNT_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    line_start,
   input  logic                    win_en,
   input  logic [CODE_W-1:0]       adc_code,
   input  logic [TGT_W-1:0]        black_tgt,
   output logic signed [ACC_W-1:0] acc_q,
   output logic [CNT_W-1:0]        cnt_q
);
   localparam int DW = CODE_W + 1;

   logic signed [DW-1:0]    diff;
   logic signed [ACC_W-1:0] diff_x;
   logic                    cnt_full;

   always_comb begin
      diff     = $signed({1'b0, adc_code}) - $signed({{(DW-TGT_W){1'b0}}, black_tgt});
      diff_x   = {{(ACC_W-DW){diff[DW-1]}}, diff};
      cnt_full = &cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (line_start) begin
         acc_q <= win_en ? diff_x : '0;
         cnt_q <= win_en ? CNT_W'(1) : '0;
      end else if (win_en && !cnt_full) begin
         acc_q <= acc_q + diff_x;
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/clamp_pacer.sv
module clamp_pacer #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic [DIV_W-1:0] line_div,
   output logic             fire,
   output logic [DIV_W-1:0] lcnt_q
);
   always_comb fire = (lcnt_q >= line_div);

   always_ff @(posedge clk) begin
      if (!rst_n)
         lcnt_q <= '0;
      else if (line_start)
         lcnt_q <= fire ? '0 : lcnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/clamp_filter.sv
module clamp_filter #(
   parameter int ACC_W         = 24,
   parameter int CNT_W         = 11,
   parameter int GAIN_W        = 3,
   parameter int CORR_W        = 10,
   parameter int TGT_W         = 8,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     update,
   input  logic                     loop_on,
   input  logic [TGT_W-1:0]         black_tgt,
   input  logic signed [ACC_W-1:0]  acc,
   input  logic [CNT_W-1:0]         cnt,
   input  logic [GAIN_W-1:0]        gain_sh,
   output logic signed [CORR_W-1:0] corr_q
);
   localparam int SH_W = clamp_pkg::shift_width(CNT_W);

   logic [SH_W-1:0]         msb;
   logic [SH_W-1:0]         sh;
   logic signed [ACC_W-1:0] avg;
   logic signed [ACC_W-1:0] step;
   logic signed [ACC_W:0]   sum;
   logic                    fits;
   logic signed [CORR_W-1:0] next_c;

   always_comb begin
      msb = '0;
      for (int i = 0; i < CNT_W; i++)
         if (cnt[i]) msb = SH_W'(i);
   end

   generate
      if (ROUND_NEAREST) begin : g_near
         logic below;
         always_comb begin
            below = (msb == '0) ? 1'b0 : cnt[msb - SH_W'(1)];
            sh    = below ? msb + SH_W'(1) : msb;
         end
      end else begin : g_floor
         always_comb sh = msb;
      end
   endgenerate

   always_comb begin
      avg  = acc >>> sh;
      step = avg >>> gain_sh;
      sum  = {{(ACC_W+1-CORR_W){corr_q[CORR_W-1]}}, corr_q} + {step[ACC_W-1], step};
      fits = (&sum[ACC_W:CORR_W-1]) | ~(|sum[ACC_W:CORR_W-1]);
      if (fits)
         next_c = sum[CORR_W-1:0];
      else if (sum[ACC_W])
         next_c = {1'b1, {(CORR_W-1){1'b0}}};
      else
         next_c = {1'b0, {(CORR_W-1){1'b1}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         corr_q <= '0;
      else if (!loop_on)
         corr_q <= $signed({{(CORR_W-TGT_W){1'b0}}, black_tgt});
      else if (update)
         corr_q <= next_c;
   end
endmodule

// File: rtl/clamp_servo.sv
module clamp_servo #(
   parameter int CODE_W        = clamp_pkg::DEF_CODE_W,
   parameter int TGT_W         = clamp_pkg::DEF_TGT_W,
   parameter int CORR_W        = clamp_pkg::DEF_CORR_W,
   parameter int CNT_W         = clamp_pkg::DEF_CNT_W,
   parameter int DIV_W         = clamp_pkg::DEF_DIV_W,
   parameter int GAIN_W        = clamp_pkg::DEF_GAIN_W,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     line_start,
   input  logic                     win_en,
   input  logic [CODE_W-1:0]        adc_code,
   input  logic [TGT_W-1:0]         black_tgt,
   input  logic                     loop_on,
   input  logic [DIV_W-1:0]         line_div,
   input  logic [GAIN_W-1:0]        gain_sh,
   output logic signed [CORR_W-1:0] corr_out
);
   localparam int ACC_W = CODE_W + 1 + CNT_W;

   generate
      if (TGT_W > CODE_W) begin : g_bad_tgt
         $error("clamp_servo: TGT_W must not exceed CODE_W");
      end
      if (CORR_W <= TGT_W) begin : g_bad_corr
         $error("clamp_servo: CORR_W must exceed TGT_W to hold the fixed offset");
      end
      if (ACC_W <= CORR_W) begin : g_bad_acc
         $error("clamp_servo: accumulator narrower than correction word");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("clamp_servo: CNT_W too small");
      end
   endgenerate

   logic signed [ACC_W-1:0] acc;
   logic [CNT_W-1:0]        win_cnt;
   logic                    fire;
   logic [DIV_W-1:0]        lcnt;
   logic                    update;

   clamp_win_acc #(
      .CODE_W(CODE_W), .TGT_W(TGT_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .win_en(win_en),
      .adc_code(adc_code), .black_tgt(black_tgt), .acc_q(acc), .cnt_q(win_cnt)
   );

   clamp_pacer #(.DIV_W(DIV_W)) u_pace (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_div(line_div),
      .fire(fire), .lcnt_q(lcnt)
   );

   always_comb update = line_start & fire & loop_on & (win_cnt != '0);

   clamp_filter #(
      .ACC_W(ACC_W), .CNT_W(CNT_W), .GAIN_W(GAIN_W), .CORR_W(CORR_W),
      .TGT_W(TGT_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_filt (
      .clk(clk), .rst_n(rst_n), .update(update), .loop_on(loop_on),
      .black_tgt(black_tgt), .acc(acc), .cnt(win_cnt), .gain_sh(gain_sh),
      .corr_q(corr_out)
   );
endmodule

// File: rtl/clamp_servo_chk.sv
module clamp_servo_chk #(
   parameter int TGT_W  = 8,
   parameter int CORR_W = 10,
   parameter int CNT_W  = 11,
   parameter int DIV_W  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     line_start,
   input logic                     loop_on,
   input logic [TGT_W-1:0]         black_tgt,
   input logic signed [CORR_W-1:0] corr_out,
   input logic [CNT_W-1:0]         win_cnt,
   input logic [DIV_W-1:0]         lcnt
);
   a_r9_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_on && !line_start) |=> $stable(corr_out));

   a_r8_fixed_offset: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_on |=> (corr_out == $signed({{(CORR_W-TGT_W){1'b0}}, $past(black_tgt)})));

   a_r6_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && loop_on && win_cnt == '0) |=> $stable(corr_out));

   a_r7_pacer_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(lcnt));

   a_r7_pacer_step: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (lcnt == '0 || lcnt == $past(lcnt) + DIV_W'(1)));
endmodule

bind clamp_servo clamp_servo_chk #(
   .TGT_W(TGT_W), .CORR_W(CORR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start), .loop_on(loop_on),
   .black_tgt(black_tgt), .corr_out(corr_out), .win_cnt(win_cnt), .lcnt(lcnt)
);

// File: tb/sim_clamp_servo.sv
module sim_clamp_servo;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              line_start;
   logic              win_en;
   logic [11:0]       adc_code;
   logic [7:0]        black_tgt;
   logic              loop_on;
   logic [3:0]        line_div;
   logic [2:0]        gain_sh;
   logic signed [9:0] corr_out;

   clamp_servo u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .win_en(win_en),
      .adc_code(adc_code), .black_tgt(black_tgt), .loop_on(loop_on),
      .line_div(line_div), .gain_sh(gain_sh), .corr_out(corr_out)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // settings applied at the next driven cycle
   int s_tgt = 0, s_div = 0, s_gain = 0;
   bit s_loop = 1;
   string cur_req = "R1";

   // reference model
   longint m_acc = 0;
   int m_cnt = 0, m_lcnt = 0, m_corr = 0;

   typedef struct { int exp; string req; } exp_t;
   exp_t sb[$];

   task automatic tick(bit ls, bit win, int code);
      @(negedge clk);
      line_start = ls; win_en = win; adc_code = code[11:0];
      black_tgt = s_tgt[7:0]; line_div = s_div[3:0]; gain_sh = s_gain[2:0];
      loop_on = s_loop;
      if (ls) begin
         bit f;
         f = (m_lcnt >= s_div);                       // R7
         m_lcnt = f ? 0 : m_lcnt + 1;
         if (s_loop && f && m_cnt > 0) begin          // R6
            int sh;
            longint avg, nv;
            sh = 0;
            for (int i = 0; i < 11; i++) if (((m_cnt >> i) & 1) != 0) sh = i;
            avg = m_acc >>> sh;                       // R3
            nv  = m_corr + (avg >>> s_gain);          // R4
            if (nv > 511) nv = 511;                   // R5
            if (nv < -512) nv = -512;
            m_corr = int'(nv);
         end
      end
      if (!s_loop) m_corr = s_tgt;                    // R8
      if (ls) begin                                   // R2
         m_acc = win ? longint'(code - s_tgt) : 0;
         m_cnt = win ? 1 : 0;
      end else if (win) begin
         m_acc += code - s_tgt;
         m_cnt++;
      end
      if (ls) sb.push_back('{m_corr, cur_req});
   endtask

   // one line: gap, window of n samples, gap, then the next line_start
   task automatic run_line(int pre, int n, int val, int post, int junk);
      for (int i = 0; i < pre; i++)  tick(0, 0, junk);
      for (int i = 0; i < n; i++)    tick(0, 1, val);
      for (int i = 0; i < post; i++) tick(0, 0, junk);
      tick(1, 0, junk);
   endtask

   // monitor: result due one cycle after the line_start cycle
   bit pend = 0;
   always @(posedge clk) pend = rst_n && line_start;
   always @(negedge clk) begin
      if (pend) begin
         pend = 0;
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL scoreboard: result with no expected item, actual=%0d expected=none", corr_out);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (int'(corr_out) != e.exp) begin
               bad++;
               $display("FAIL %s: corr_out actual=%0d expected=%0d", e.req, corr_out, e.exp);
            end
         end
      end
   end

   initial begin
      rst_n = 0; line_start = 0; win_en = 0; adc_code = 0;
      black_tgt = 0; loop_on = 1; line_div = 0; gain_sh = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      total++;
      if (corr_out !== 10'sd0) begin
         bad++;
         $display("FAIL R1: corr_out after reset actual=%0d expected=0", corr_out);
      end

      // R6: first line has an empty window
      s_tgt = 64; s_gain = 0; s_div = 0; cur_req = "R6";
      run_line(3, 0, 0, 3, 900);
      // R3/R4: 16 samples of 80 vs target 64
      cur_req = "R3";
      run_line(5, 16, 80, 4, 3000);
      // R2: junk codes 4095 outside a 20-sample window, gain 2
      s_gain = 2; cur_req = "R2";
      run_line(6, 20, 100, 6, 4095);
      // R4: negative error, gain 0
      s_gain = 0; cur_req = "R4";
      run_line(2, 8, 0, 2, 4095);
      // R2: sample in the line_start cycle opens the new window
      cur_req = "R2";
      tick(1, 1, 1000);
      run_line(1, 15, 64, 1, 0);
      // R5: drive to the negative limit
      s_tgt = 255; cur_req = "R5";
      for (int l = 0; l < 4; l++) run_line(2, 32, 0, 2, 4000);
      // R5: drive to the positive limit
      s_tgt = 0; s_gain = 1;
      for (int l = 0; l < 4; l++) run_line(2, 64, 4095, 2, 0);
      // R7: update every third line
      s_tgt = 128; s_gain = 0; s_div = 2; cur_req = "R7";
      for (int l = 0; l < 6; l++) run_line(2, 16, 64 + 8 * l, 2, 4095);
      // R6: firing line with an empty window under a divider
      cur_req = "R6";
      for (int l = 0; l < 3; l++) run_line(2, 0, 0, 4, 10);
      // R8: loop disabled acts as fixed offset
      s_div = 0; s_loop = 0; s_tgt = 200; cur_req = "R8";
      run_line(2, 16, 4095, 2, 0);
      s_tgt = 37;
      run_line(2, 16, 0, 2, 0);
      // R8/R9: re-enabled loop starts from the offset
      s_loop = 1; s_tgt = 37; cur_req = "R9";
      run_line(3, 16, 37, 3, 4095);
      run_line(3, 24, 53, 3, 4095);
      s_gain = 3;
      run_line(3, 40, 20, 3, 4095);

      repeat (3) tick(0, 0, 0);
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL scoreboard: leftover items actual=%0d expected=0", sb.size());
      end
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: run actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule